// File: doc/BRIEF.md
# Timer Capture Unit

Four channels each hold a frozen copy of a free-running 16-bit timer count. A channel is triggered in one of two ways, chosen per channel in a configuration register. In pin mode an edge on the channel's input pin copies the timer into the channel register. The pin passes through a two-stage synchronizer, and the active edge (rising or falling) is chosen per channel. In software mode, a register write that touches the low byte of the channel's own capture register triggers the copy. The timer value is stored, and the data on the write bus is thrown away.

Each capture sets a sticky per-channel flag. Software clears a flag by writing a one to its bit in the flag register. Software reads all state back through a combinational read port. The timer and any interrupt logic that consumes the flags are outside the block.

Top module: `tcap_unit`

## Requirements
- R1: After reset every capture register, the configuration register (address 4) and the flag register (address 5) read as zero, and `cap_flag` is zero. The reset state therefore selects pin mode with rising-edge triggering on every channel.
- R2: In pin mode with rising edge selected (config bit 4+n = 0), a low-to-high change of `cap_pin[n]` made before clock edge k stores `timer_val`, as sampled at edge k+2, into capture register n (address n). At that same edge it sets flag n.
- R3: With config bit 4+n = 1, channel n captures on a high-to-low pin change with the same latency, and ignores a low-to-high change.
- R4: In software mode (config bit n = 1), a write to address n with `wr_be[0]` set stores the `timer_val` present at that edge and sets flag n. The write data is not stored in any byte.
- R5: In software mode, a write to address n with `wr_be[0]` clear and `wr_be[1]` set stores `wr_data[15:8]` into bits 15:8. It keeps bits 7:0 and leaves flag n unchanged.
- R6: In pin mode, a write to address n stores each byte whose `wr_be` bit is set, keeps the other bytes, and leaves flag n unchanged.
- R7: In software mode, changes on `cap_pin[n]` neither alter capture register n nor set flag n.
- R8: Flag n stays set until a write to address 5 with `wr_data[n]` = 1. A write with `wr_data[n]` = 0 leaves it set. A clear affects only the bits written as one.
- R9: When a capture on channel n and a clear of flag n fall on the same edge, the flag ends up set.
- R10: In pin mode, when a pin capture and a register write to the same channel fall on the same edge, the timer value is stored.
- R11: A write to address 4 loads `wr_data[3:0]` as the per-channel mode bits (1 = software) and `wr_data[7:4]` as the per-channel edge select bits (1 = falling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 capture, 4 config, 5 flags |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| timer_val | input | 16 | Current timer count |
| cap_pin | input | 4 | Asynchronous capture inputs |
| cap_flag | output | 4 | Sticky capture flags |

## Verification
The bench changes the timer on every cycle after a pin edge. A design with one synchronizer stage too few or too many would then store a neighbouring count. It writes capture registers in both modes and with partial byte enables. A design that let the written low byte through in software mode, or that triggered on a high-byte-only write, would read back the wrong value or raise a spurious flag. It also makes a pin capture collide with a flag clear, and separately with a data write to the same register. A design that gives the write priority would lose the flag or store bus data instead of the timer count.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic {
        TRIG_PIN = 1'b0,
        TRIG_SW  = 1'b1
    } trig_mode_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det
    import tcap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  edge_pol_e pol,
    output logic      hit
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edet_t;

    edet_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin_in};
        d.prev = q.sync[LAST];
        if (pol == EDGE_FALL) begin
            hit = q.prev & ~q.sync[LAST];
        end else begin
            hit = ~q.prev & q.sync[LAST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  trig_mode_e         mode,
    input  logic               pin_hit,
    input  logic               wr_sel,
    input  logic [TMR_W/8-1:0] wr_be,
    input  logic [TMR_W-1:0]   wr_data,
    input  logic [TMR_W-1:0]   timer_val,
    input  logic               flag_clr,
    output logic [TMR_W-1:0]   cap_val,
    output logic               flag
);

    localparam int NBYTES = TMR_W / 8;

    typedef struct packed {
        logic [TMR_W-1:0] val;
        logic             flag;
    } chan_t;

    chan_t q, d;
    logic  sw_hit;
    logic  any_hit;

    always_comb begin
        d       = q;
        sw_hit  = (mode == TRIG_SW) && wr_sel && wr_be[0];
        any_hit = sw_hit || ((mode == TRIG_PIN) && pin_hit);

        if (any_hit) begin
            d.val = timer_val;
        end else if (wr_sel) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b]) begin
                    d.val[b*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end

        if (any_hit) begin
            d.flag = 1'b1;
        end else if (flag_clr) begin
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cap_val = q.val;
    assign flag    = q.flag;

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_CH + 2),
    parameter int BE_W        = TMR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [TMR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TMR_W-1:0]  rd_data,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic [NUM_CH-1:0] cap_pin,
    output logic [NUM_CH-1:0] cap_flag
);

    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH + 1);
    localparam int                CFG_W     = 2 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] pol;
        logic [NUM_CH-1:0] mode;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [NUM_CH-1:0]            mode_vec;
    logic [NUM_CH-1:0]            pin_hit;
    logic [NUM_CH-1:0]            flag_clr;
    logic [NUM_CH-1:0]            wr_sel;
    logic [NUM_CH-1:0][TMR_W-1:0] cap_vals;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (wr_addr == CFG_ADDR)) begin
            cfg_d = cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_vec = cfg_q.mode;

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            wr_sel[n]   = wr_en && (wr_addr == ADDR_W'(n));
            flag_clr[n] = wr_en && (wr_addr == FLAG_ADDR) && wr_data[n];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tcap_edge_det #(
            .STAGES(SYNC_STAGES)
        ) u_edet (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_in(cap_pin[g]),
            .pol   (edge_pol_e'(cfg_q.pol[g])),
            .hit   (pin_hit[g])
        );

        tcap_channel #(
            .TMR_W(TMR_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (trig_mode_e'(cfg_q.mode[g])),
            .pin_hit  (pin_hit[g]),
            .wr_sel   (wr_sel[g]),
            .wr_be    (wr_be),
            .wr_data  (wr_data),
            .timer_val(timer_val),
            .flag_clr (flag_clr[g]),
            .cap_val  (cap_vals[g]),
            .flag     (cap_flag[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (rd_addr == ADDR_W'(n)) begin
                rd_data = cap_vals[n];
            end
        end
        if (rd_addr == CFG_ADDR) begin
            rd_data = TMR_W'(cfg_q);
        end else if (rd_addr == FLAG_ADDR) begin
            rd_data = TMR_W'(cap_flag);
        end
    end

endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
    parameter int NUM_CH = 4,
    parameter int TMR_W  = 16,
    parameter int ADDR_W = 3,
    parameter int BE_W   = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [BE_W-1:0]                 wr_be,
    input logic [TMR_W-1:0]                wr_data,
    input logic [TMR_W-1:0]                timer_val,
    input logic [NUM_CH-1:0]               cap_flag,
    input logic [NUM_CH-1:0]               mode_vec,
    input logic [NUM_CH-1:0][TMR_W-1:0]    cap_vals
);

    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH + 1);

    logic [NUM_CH-1:0] clr_vec;
    assign clr_vec = (wr_en && (wr_addr == FLAG_ADDR)) ? wr_data[NUM_CH-1:0] : '0;

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cap_flag) & ~$past(clr_vec)) & ~cap_flag) == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4
        sw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == ADDR_W'(g)) && wr_be[0] && mode_vec[g])
            |=> (cap_vals[g] == $past(timer_val)) && cap_flag[g]);

        // R7
        sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[g] && !(wr_en && (wr_addr == ADDR_W'(g))))
            |=> $stable(cap_vals[g]));

        // R5
        hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == ADDR_W'(g)) && !wr_be[0] && wr_be[1] && mode_vec[g])
            |=> (cap_vals[g][15:8] == $past(wr_data[15:8]))
                && (cap_flag[g] == $past(cap_flag[g])));

        // R2
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cap_flag[g])
            |-> $past(!mode_vec[g] || (wr_en && (wr_addr == ADDR_W'(g)) && wr_be[0])));
    end

endmodule

bind tcap_unit tcap_unit_chk #(
    .NUM_CH(NUM_CH),
    .TMR_W (TMR_W),
    .ADDR_W(ADDR_W),
    .BE_W  (BE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .timer_val(timer_val),
    .cap_flag (cap_flag),
    .mode_vec (mode_vec),
    .cap_vals (cap_vals)
);

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] timer_val = '0;
    logic [3:0]  cap_pin = '0;
    logic [3:0]  cap_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    tcap_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .timer_val(timer_val),
        .cap_pin  (cap_pin),
        .cap_flag (cap_flag)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 16'h0);
        end
        check("R1 reset flags", {12'h0, cap_flag}, 16'h0);
    endtask

    task automatic t_rise;
        logic [15:0] v;
        @(negedge clk); cap_pin[0] = 1'b1; timer_val = 16'h1000;
        @(negedge clk); timer_val = 16'h1001;
        @(negedge clk); timer_val = 16'h1002;
        @(negedge clk); timer_val = 16'h1003;
        rd(3'd0, v);
        check("R2 rise capture latency", v, 16'h1002);
        check("R2 flag set", {15'h0, cap_flag[0]}, 16'h1);
        check("R2 other flags", {12'h0, cap_flag & 4'b1110}, 16'h0);
        wr(3'd5, 2'b11, 16'h0001);
    endtask

    task automatic t_fall;
        logic [15:0] v;
        wr(3'd4, 2'b11, 16'h0040);
        rd(3'd4, v);
        check("R11 config readback", v, 16'h0040);
        @(negedge clk); cap_pin[2] = 1'b1; timer_val = 16'h1111;
        idle(5);
        rd(3'd2, v);
        check("R3 rising ignored", v, 16'h0000);
        check("R3 no flag on rise", {15'h0, cap_flag[2]}, 16'h0);
        @(negedge clk); cap_pin[2] = 1'b0; timer_val = 16'h2220;
        @(negedge clk); timer_val = 16'h2221;
        @(negedge clk); timer_val = 16'h2222;
        @(negedge clk); timer_val = 16'h2223;
        rd(3'd2, v);
        check("R3 falling capture", v, 16'h2222);
        check("R3 flag on fall", {15'h0, cap_flag[2]}, 16'h1);
        wr(3'd5, 2'b11, 16'h0004);
        wr(3'd4, 2'b11, 16'h0000);
    endtask

    task automatic t_sw;
        logic [15:0] v;
        wr(3'd4, 2'b11, 16'h0001);
        timer_val = 16'hBEEF;
        wr(3'd0, 2'b11, 16'h1234);
        rd(3'd0, v);
        check("R4 sw capture discards data", v, 16'hBEEF);
        check("R4 sw flag", {15'h0, cap_flag[0]}, 16'h1);
        wr(3'd5, 2'b11, 16'h0001);
        timer_val = 16'h00C4;
        wr(3'd0, 2'b01, 16'h7777);
        rd(3'd0, v);
        check("R4 low-byte-only capture", v, 16'h00C4);
        wr(3'd5, 2'b11, 16'h0001);
        timer_val = 16'h9999;
        wr(3'd0, 2'b10, 16'h5A33);
        rd(3'd0, v);
        check("R5 high byte write", v, 16'h5AC4);
        check("R5 no flag", {15'h0, cap_flag[0]}, 16'h0);
    endtask

    task automatic t_pin_write;
        logic [15:0] v;
        wr(3'd1, 2'b11, 16'hA5C3);
        rd(3'd1, v);
        check("R6 full write", v, 16'hA5C3);
        wr(3'd1, 2'b01, 16'h0077);
        rd(3'd1, v);
        check("R6 low byte write", v, 16'hA577);
        check("R6 no flag", {15'h0, cap_flag[1]}, 16'h0);
    endtask

    task automatic t_sw_ignores_pin;
        logic [15:0] v;
        wr(3'd4, 2'b11, 16'h0009);
        timer_val = 16'h3333;
        @(negedge clk); cap_pin[3] = 1'b1;
        idle(5);
        @(negedge clk); cap_pin[3] = 1'b0;
        idle(5);
        rd(3'd3, v);
        check("R7 pin ignored value", v, 16'h0000);
        check("R7 pin ignored flag", {15'h0, cap_flag[3]}, 16'h0);
    endtask

    task automatic t_flags;
        logic [15:0] v;
        timer_val = 16'h0A0A;
        wr(3'd0, 2'b01, 16'h0);
        wr(3'd3, 2'b01, 16'h0);
        wr(3'd5, 2'b11, 16'h0000);
        check("R8 zero write keeps", {12'h0, cap_flag}, 16'h0009);
        wr(3'd5, 2'b11, 16'h0008);
        rd(3'd5, v);
        check("R8 selective clear", v, 16'h0001);
        wr(3'd5, 2'b11, 16'h0001);
        check("R8 cleared", {12'h0, cap_flag}, 16'h0);
        wr(3'd4, 2'b11, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        cap_pin[1] = 1'b0;
        idle(4);
        @(negedge clk); cap_pin[1] = 1'b1; timer_val = 16'h4000;
        idle(4);
        check("R9 setup flag", {15'h0, cap_flag[1]}, 16'h1);
        @(negedge clk); cap_pin[1] = 1'b0;
        idle(4);
        @(negedge clk); cap_pin[1] = 1'b1; timer_val = 16'h4100;
        @(negedge clk); timer_val = 16'h4101;
        @(negedge clk); timer_val = 16'h4102;
        wr_en = 1'b1; wr_addr = 3'd5; wr_be = 2'b11; wr_data = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        check("R9 set beats clear", {15'h0, cap_flag[1]}, 16'h1);
        @(negedge clk); cap_pin[1] = 1'b0;
        idle(4);
        @(negedge clk); cap_pin[1] = 1'b1; timer_val = 16'h4300;
        @(negedge clk); timer_val = 16'h4310;
        @(negedge clk); timer_val = 16'h4321;
        wr_en = 1'b1; wr_addr = 3'd1; wr_be = 2'b11; wr_data = 16'h9999;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        rd(3'd1, v);
        check("R10 capture beats write", v, 16'h4321);
    endtask

    initial begin
        idle(3);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        t_reset;
        t_rise;
        t_fall;
        t_sw;
        t_pin_write;
        t_sw_ignores_pin;
        t_flags;
        t_collide;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule